// File: doc/BRIEF.md
# Costas Carrier Tracking Loop

This block removes residual carrier phase and frequency from a stream of complex baseband chips. Each valid chip is de-rotated by a complex multiplier. The multiplier takes its sine and cosine from a numerically controlled oscillator (NCO), which is a 16-bit phase accumulator feeding a quarter-wave sine lookup of 64 steps. A four-phase Costas detector turns the de-rotated chip into a phase error. The error feeds a proportional-plus-integral (lead/lag) filter whose output steers the NCO phase increment.

The filter takes a new error only on chips where the de-rotated sign pattern changes. On all other chips the integrator holds and the NCO keeps running at the current frequency estimate. The integrator is exported as that estimate. A synchronous load presets the NCO phase and clears the integrator when tracking starts. The chip after a load, or after reset, only seeds the sign history.

Top module: `costas_track`

## Requirements
- R1: After reset and before any stimulus, outValid, trackStrobe, outI, outQ, errOut, freqEst and phase are all zero.
- R2: When load is high at a clock edge, phase takes loadPhase, freqEst becomes 0 and outValid is low after that edge. The first valid chip after a load or after reset never updates the loop (trackStrobe stays low).
- R3: A valid chip (I, Q) at NCO phase p appears one cycle later with outValid high as outI = (I·cos p + Q·sin p) >>> 7 and outQ = (Q·cos p − I·sin p) >>> 7. Both use floor division. The two top phase bits select the quadrant and the next six select the table step. sin/cos equal 0/+127 at phase 0x0000, +127/0 at 0x4000, 0/−127 at 0x8000 and −127/0 at 0xC000.
- R4: errOut = s(outI)·outQ − s(outQ)·outI, where s(x) is −1 for negative x and +1 otherwise. The result is clamped to the signed 7-bit range −64..63 and presented with the same chip.
- R5: trackStrobe is high for a chip exactly when the sign bit of its de-rotated I or Q differs from that of the previous valid chip. Any chip covered by the R2 exception is excluded.
- R6: On a strobed chip, freqEst increases by errOut >>> kiShift (arithmetic shift).
- R7: On every valid chip the phase advances by the updated freqEst, plus errOut >>> kpShift when the chip is strobed. The sum wraps modulo 2^16.
- R8: With inValid and load both low, phase and freqEst hold, and outValid and trackStrobe are low after the edge.
- R9: A valid chip without a sign change leaves freqEst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A chip is presented on inI/inQ |
| inI | input | 8 | In-phase chip sample, signed |
| inQ | input | 8 | Quadrature chip sample, signed |
| load | input | 1 | Preset NCO phase, clear integrator |
| loadPhase | input | 16 | Phase value used by load |
| kpShift | input | 4 | Right shift applied to the error for the proportional path |
| kiShift | input | 4 | Right shift applied to the error for the integral path |
| outValid | output | 1 | De-rotated chip is valid |
| outI | output | 9 | De-rotated in-phase value, signed |
| outQ | output | 9 | De-rotated quadrature value, signed |
| errOut | output | 7 | Clamped Costas phase error, signed |
| trackStrobe | output | 1 | The loop filter consumed this chip's error |
| freqEst | output | 16 | Integrator state, the frequency offset estimate, signed |
| phase | output | 16 | NCO phase accumulator |

## Verification
The bench sweeps a grid of positive chip values at each of the four quadrant phases. These sweeps catch a swapped sine and cosine, a wrong quadrant mirror or a rounding error in the multiplier scaling, because any of these moves outI or outQ off the floor-divided products. Single sign-changing chips are then applied after a load across three gain pairs. The chip values include zeros and near-full-scale values. This exposes a missing error clamp (errOut escaping −64..63), an update on a chip without a sign change (freqEst drifting), a shift in the wrong path, and an update taken on the first chip after a load. Idle cycles after each trial show whether the NCO keeps advancing without input.

// File: rtl/costas_pkg.sv
package costas_pkg;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic load;     // preset phase, clear integrator
    logic advance;  // a chip is consumed this cycle
    logic update;   // loop filter takes the error this cycle
  } trkStrobe_t;

endpackage

// File: rtl/costas_sine.sv
module costas_sine #(
  parameter int SW      = 8,
  parameter int ACCW    = 16,
  parameter int LUTBITS = 6
) (
  input  logic        [ACCW-1:0] phase,
  output logic signed [SW-1:0]   sinV,
  output logic signed [SW-1:0]   cosV
);

  localparam int QDEPTH = 1 << LUTBITS;
  localparam int HALF   = 2 * QDEPTH;
  localparam int AMP    = (1 << (SW - 1)) - 1;
  localparam logic [LUTBITS:0]  QD      = (LUTBITS + 1)'(QDEPTH);
  localparam logic [ACCW-1:0]   QUARTER = ACCW'(1) << (ACCW - 2);

  // Rational approximation of a half sine over 0..HALF steps.
  function automatic int quarterSine(input int u);
    int num;
    int den;
    num = 4 * u * (HALF - u);
    den = (5 * HALF * HALF) / 4 - u * (HALF - u);
    return (AMP * num) / den;
  endfunction

  logic signed [SW-1:0] qTab [0:QDEPTH];

  for (genvar k = 0; k <= QDEPTH; k++) begin : g_tab
    assign qTab[k] = SW'(quarterSine(k));
  end

  function automatic logic signed [SW-1:0] pick(input logic [ACCW-1:0] ph);
    logic [1:0]           quad;
    logic [LUTBITS:0]     idx;
    logic [LUTBITS:0]     addr;
    logic signed [SW-1:0] mag;
    quad = ph[ACCW-1 -: 2];
    idx  = {1'b0, ph[ACCW-3 -: LUTBITS]};
    addr = quad[0] ? (QD - idx) : idx;
    mag  = qTab[addr];
    return quad[1] ? -mag : mag;
  endfunction

  always_comb begin
    sinV = pick(phase);
    cosV = pick(phase + QUARTER);
  end

endmodule

// File: rtl/costas_ctrl.sv
module costas_ctrl
  import costas_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       load,
  input  logic       rotSignI,
  input  logic       rotSignQ,
  output trkStrobe_t strb
);

  logic prevSignI, prevSignQ, fresh;

  always_comb begin
    strb.load    = load;
    strb.advance = inValid && !load;
    strb.update  = strb.advance && !fresh &&
                   ((rotSignI ^ prevSignI) || (rotSignQ ^ prevSignQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fresh     <= 1'b1;
      prevSignI <= 1'b0;
      prevSignQ <= 1'b0;
    end else if (load) begin
      fresh <= 1'b1;
    end else if (inValid) begin
      fresh     <= 1'b0;
      prevSignI <= rotSignI;
      prevSignQ <= rotSignQ;
    end
  end

endmodule

// File: rtl/costas_dp.sv
module costas_dp
  import costas_pkg::*;
#(
  parameter int SW      = 8,
  parameter int ERRW    = 7,
  parameter int INTW    = 16,
  parameter int ACCW    = 16,
  parameter int LUTBITS = 6,
  parameter int SHW     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trkStrobe_t           strb,
  input  logic signed [SW-1:0] inI,
  input  logic signed [SW-1:0] inQ,
  input  logic [ACCW-1:0]      loadPhase,
  input  logic [SHW-1:0]       kpShift,
  input  logic [SHW-1:0]       kiShift,
  output logic                 rotSignI,
  output logic                 rotSignQ,
  output logic                 outValid,
  output logic signed [SW:0]   outI,
  output logic signed [SW:0]   outQ,
  output logic signed [ERRW-1:0] errOut,
  output logic                 trackStrobe,
  output logic signed [INTW-1:0] freqEst,
  output logic [ACCW-1:0]      phase
);

  localparam int ROTW  = SW + 1;
  localparam int PRODW = 2 * SW + 1;
  localparam int EW    = ROTW + 2;
  localparam int IW1   = INTW + 1;
  localparam int EMAXI = (1 << (ERRW - 1)) - 1;
  localparam logic signed [EW-1:0]  EMAX = EW'(EMAXI);
  localparam logic signed [EW-1:0]  EMIN = EW'(-EMAXI - 1);
  localparam logic signed [IW1-1:0] IMAX = IW1'((64'sd1 <<< (INTW - 1)) - 1);
  localparam logic signed [IW1-1:0] IMIN = -IMAX - IW1'(1);

  logic [ACCW-1:0]         phaseQ;
  logic signed [INTW-1:0]  integQ;
  logic signed [SW-1:0]    sinV, cosV;

  costas_sine #(.SW(SW), .ACCW(ACCW), .LUTBITS(LUTBITS)) u_sine (
    .phase(phaseQ), .sinV(sinV), .cosV(cosV)
  );

  logic signed [PRODW-1:0] xI, xQ, xC, xS, accI, accQ, shI, shQ;
  logic signed [ROTW-1:0]  rotI, rotQ;
  logic signed [EW-1:0]    eRI, eRQ, rawErr, clampErr;
  logic signed [ERRW-1:0]  err;
  logic signed [INTW-1:0]  propTerm, intTerm, integSat, integNext;
  logic signed [IW1-1:0]   integSum;
  logic [ACCW-1:0]         phaseNext;

  always_comb begin
    // complex de-rotation by the NCO phase
    xI   = PRODW'(inI);
    xQ   = PRODW'(inQ);
    xC   = PRODW'(cosV);
    xS   = PRODW'(sinV);
    accI = xI * xC + xQ * xS;
    accQ = xQ * xC - xI * xS;
    shI  = accI >>> (SW - 1);
    shQ  = accQ >>> (SW - 1);
    rotI = ROTW'(shI);
    rotQ = ROTW'(shQ);

    // four-phase Costas detector with clamp
    eRI    = EW'(rotI);
    eRQ    = EW'(rotQ);
    rawErr = (rotI[ROTW-1] ? -eRQ : eRQ) - (rotQ[ROTW-1] ? -eRI : eRI);
    if (rawErr > EMAX)      clampErr = EMAX;
    else if (rawErr < EMIN) clampErr = EMIN;
    else                    clampErr = rawErr;
    err = ERRW'(clampErr);

    // lead/lag filter
    propTerm = INTW'(err) >>> kpShift;
    intTerm  = INTW'(err) >>> kiShift;
    integSum = IW1'(integQ) + IW1'(intTerm);
    if (integSum > IMAX)      integSat = INTW'(IMAX);
    else if (integSum < IMIN) integSat = INTW'(IMIN);
    else                      integSat = INTW'(integSum);
    integNext = strb.update ? integSat : integQ;
    phaseNext = phaseQ + ACCW'(integNext) +
                (strb.update ? ACCW'(propTerm) : ACCW'(0));
  end

  assign rotSignI = rotI[ROTW-1];
  assign rotSignQ = rotQ[ROTW-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ      <= '0;
      integQ      <= '0;
      outValid    <= 1'b0;
      trackStrobe <= 1'b0;
      outI        <= '0;
      outQ        <= '0;
      errOut      <= '0;
    end else if (strb.load) begin
      phaseQ      <= loadPhase;
      integQ      <= '0;
      outValid    <= 1'b0;
      trackStrobe <= 1'b0;
    end else begin
      outValid    <= strb.advance;
      trackStrobe <= strb.update;
      if (strb.advance) begin
        outI   <= rotI;
        outQ   <= rotQ;
        errOut <= err;
        phaseQ <= phaseNext;
        integQ <= integNext;
      end
    end
  end

  assign freqEst = integQ;
  assign phase   = phaseQ;

endmodule

// File: rtl/costas_track.sv
module costas_track
  import costas_pkg::*;
#(
  parameter int SW      = 8,
  parameter int ERRW    = 7,
  parameter int INTW    = 16,
  parameter int ACCW    = 16,
  parameter int LUTBITS = 6,
  parameter int SHW     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [SW-1:0]   inI,
  input  logic signed [SW-1:0]   inQ,
  input  logic                   load,
  input  logic [ACCW-1:0]        loadPhase,
  input  logic [SHW-1:0]         kpShift,
  input  logic [SHW-1:0]         kiShift,
  output logic                   outValid,
  output logic signed [SW:0]     outI,
  output logic signed [SW:0]     outQ,
  output logic signed [ERRW-1:0] errOut,
  output logic                   trackStrobe,
  output logic signed [INTW-1:0] freqEst,
  output logic [ACCW-1:0]        phase
);

  trkStrobe_t strb;
  logic       rotSignI, rotSignQ;

  costas_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .load(load),
    .rotSignI(rotSignI), .rotSignQ(rotSignQ), .strb(strb)
  );

  costas_dp #(
    .SW(SW), .ERRW(ERRW), .INTW(INTW), .ACCW(ACCW),
    .LUTBITS(LUTBITS), .SHW(SHW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inI(inI), .inQ(inQ),
    .loadPhase(loadPhase), .kpShift(kpShift), .kiShift(kiShift),
    .rotSignI(rotSignI), .rotSignQ(rotSignQ), .outValid(outValid),
    .outI(outI), .outQ(outQ), .errOut(errOut), .trackStrobe(trackStrobe),
    .freqEst(freqEst), .phase(phase)
  );

endmodule

// File: rtl/costas_track_chk.sv
module costas_track_chk #(
  parameter int SW   = 8,
  parameter int ERRW = 7,
  parameter int INTW = 16,
  parameter int ACCW = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   load,
  input logic [ACCW-1:0]        loadPhase,
  input logic                   outValid,
  input logic                   trackStrobe,
  input logic signed [INTW-1:0] freqEst,
  input logic [ACCW-1:0]        phase
);

  a_r2_load_presets: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (phase == $past(loadPhase)) && (freqEst == '0) && !outValid);

  a_r2_first_chip_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(load) && inValid && !load) |=> !trackStrobe);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !load) |=> $stable(phase) && $stable(freqEst) && !outValid && !trackStrobe);

  a_r9_freq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !load) |=> (trackStrobe || $stable(freqEst)));

  a_r5_strobe_with_chip: assert property (@(posedge clk) disable iff (!rstN)
    trackStrobe |-> outValid);

endmodule

bind costas_track costas_track_chk #(
  .SW(SW), .ERRW(ERRW), .INTW(INTW), .ACCW(ACCW)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .load(load),
  .loadPhase(loadPhase), .outValid(outValid), .trackStrobe(trackStrobe),
  .freqEst(freqEst), .phase(phase)
);

// File: tb/costas_track_tb.sv
module costas_track_tb;

  localparam int SW = 8, ERRW = 7, INTW = 16, ACCW = 16, SHW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic load = 1'b0;
  logic signed [SW-1:0] inI = '0, inQ = '0;
  logic [ACCW-1:0] loadPhase = '0;
  logic [SHW-1:0] kpShift = '0, kiShift = '0;
  logic outValid, trackStrobe;
  logic signed [SW:0] outI, outQ;
  logic signed [ERRW-1:0] errOut;
  logic signed [INTW-1:0] freqEst;
  logic [ACCW-1:0] phase;

  always #2 clk = ~clk;

  costas_track u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .load(load), .loadPhase(loadPhase), .kpShift(kpShift), .kiShift(kiShift),
    .outValid(outValid), .outI(outI), .outQ(outQ), .errOut(errOut),
    .trackStrobe(trackStrobe), .freqEst(freqEst), .phase(phase)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int errRef(input int yi, input int yq);
    int raw;
    raw = (yi < 0 ? -yq : yq) - (yq < 0 ? -yi : yi);
    if (raw > 63) return 63;
    if (raw < -64) return -64;
    return raw;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v, input int i, input int q, input bit ld, input int lp);
    inValid   = v;
    inI       = SW'(i);
    inQ       = SW'(q);
    load      = ld;
    loadPhase = ACCW'(lp);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int cosT [4] = '{127, 0, -127, 0};
    int sinT [4] = '{0, 127, 0, -127};
    int vals [6] = '{-127, -60, -1, 0, 50, 127};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 trackStrobe", int'(trackStrobe), 0);
    chk("R1 outI", int'(outI), 0);
    chk("R1 outQ", int'(outQ), 0);
    chk("R1 errOut", int'(errOut), 0);
    chk("R1 freqEst", int'(freqEst), 0);
    chk("R1 phase", int'(phase), 0);

    // quadrant sweeps: signs never change, so the loop stays idle
    for (int qd = 0; qd < 4; qd++) begin
      int lp;
      lp = qd * 16384;
      step(0, 0, 0, 1, lp);
      chk("R2 load phase", int'(phase), lp);
      chk("R2 load freqEst", int'(freqEst), 0);
      chk("R2 load outValid", int'(outValid), 0);
      for (int i = 1; i < 128; i += 4) begin
        for (int q = 1; q < 128; q += 4) begin
          int yi, yq;
          yi = (i * cosT[qd] + q * sinT[qd]) >>> 7;
          yq = (q * cosT[qd] - i * sinT[qd]) >>> 7;
          step(1, i, q, 0, 0);
          chk("R3 outValid", int'(outValid), 1);
          chk("R3 outI", int'(outI), yi);
          chk("R3 outQ", int'(outQ), yq);
          chk("R4 errOut", int'(errOut), errRef(yi, yq));
          chk("R9 trackStrobe", int'(trackStrobe), 0);
          chk("R9 freqEst", int'(freqEst), 0);
          chk("R7 phase", int'(phase), lp);
        end
      end
    end

    // single sign-change trials after a load at phase 0
    for (int kk = 0; kk < 3; kk++) begin
      int ki, kp;
      ki = kk * 3;
      kp = kk * 2 + 1;
      kiShift = SHW'(ki);
      kpShift = SHW'(kp);
      foreach (vals[a]) begin
        foreach (vals[b]) begin
          int c, d, yi, yq, e, fe, ph;
          bit trans;
          c = vals[a];
          d = vals[b];
          step(0, 0, 0, 1, 0);
          step(1, 40, 40, 0, 0);
          chk("R2 first chip no strobe", int'(trackStrobe), 0);
          chk("R2 first chip freqEst", int'(freqEst), 0);
          yi = (c * 127) >>> 7;
          yq = (d * 127) >>> 7;
          trans = (yi < 0) || (yq < 0);
          e  = errRef(yi, yq);
          fe = trans ? (e >>> ki) : 0;
          ph = trans ? ((fe + (e >>> kp)) & 65535) : 0;
          step(1, c, d, 0, 0);
          chk("R5 trackStrobe", int'(trackStrobe), int'(trans));
          chk("R4 errOut", int'(errOut), e);
          chk("R6 freqEst", int'(freqEst), fe);
          chk("R7 phase", int'(phase), ph);
          if (ph < 256) begin
            step(1, c, d, 0, 0);
            chk("R9 trackStrobe", int'(trackStrobe), 0);
            chk("R9 freqEst", int'(freqEst), fe);
            ph = (ph + fe) & 65535;
            chk("R7 phase advance", int'(phase), ph);
          end
          step(0, 0, 0, 0, 0);
          chk("R8 outValid", int'(outValid), 0);
          chk("R8 phase", int'(phase), ph);
          chk("R8 freqEst", int'(freqEst), fe);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule